// File: doc/BRIEF.md
# Reservation Station with Tag Wakeup

This block holds renamed instructions for one functional unit until their source operands exist. Each insertion carries an opcode, a destination tag and two source operands. A source either arrives with its value already valid or carries the tag of the instruction that will later produce it. The pool watches a single result broadcast bus every cycle. A pending source whose tag matches the broadcast tag copies the broadcast value and becomes ready. Entries therefore leave in dataflow order, not in the order they arrived.

Each slot runs a small state machine with three states. SLOT_FREE holds nothing. SLOT_WAIT holds an instruction with at least one pending source. SLOT_READY holds an instruction whose two sources are both valid. The transitions are as follows. FREE_TO_WAIT happens on a load while a source is still pending. FREE_TO_READY happens on a load where both sources are valid, counting a same-cycle broadcast capture. WAIT_TO_READY happens when the last pending source captures a broadcast. READY_TO_FREE happens when the issue handshake completes. Each slot also keeps an age rank that is set when it is loaded. When several slots are ready, the lowest rank, which is the oldest slot, is offered on the issue port. The rank is closed up when an older slot leaves.

Upstream decode stalls whenever `ins_ready` is low. The issue port offers the selected instruction together with both operand values until the unit accepts it.

Top module: `rs_issue_pool`

## Requirements
- R1: After reset, `ins_ready` is 1, `iss_valid` is 0 and `used_count` is 0.
- R2: `ins_ready` is 0 exactly when all NUM_SLOTS slots are occupied. An `ins_valid` pulse while full changes nothing, and `used_count` equals the number of occupied slots.
- R3: A source tag of 0 means the accompanying value field is already valid. A nonzero tag means the source is pending and its value field is ignored.
- R4: When `bc_valid` is 1 and `bc_tag` is nonzero and equal to a pending source's tag, that source takes `bc_val` at the clock edge. If this was its last pending source, the entry can issue from the following cycle.
- R5: A broadcast in the same cycle as an insert is compared with the incoming source tags, and a match is captured as in R4.
- R6: `iss_valid` is 1 only while some entry has both sources ready.
- R7: Among ready entries, the one inserted earliest is offered on the issue port.
- R8: While `iss_ready` is 0, the offer stays valid and the count is unchanged. An accepted entry stops being counted and becomes free after the accepting edge, not in the same cycle.
- R9: A broadcast with `bc_valid` 0, or with `bc_tag` 0, wakes no source.
- R10: The issue port carries the opcode and destination tag that were inserted with the offered entry, along with both operand values.
- R11: `bc_ready` is always 1, so a result broadcast is never refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request |
| ins_ready | output | 1 | A free slot exists |
| ins_op | input | OP_W | Opcode of inserted instruction |
| ins_dst | input | TAG_W | Destination tag of inserted instruction |
| ins_a_tag | input | TAG_W | Source A producer tag, 0 = value valid |
| ins_a_val | input | DATA_W | Source A value |
| ins_b_tag | input | TAG_W | Source B producer tag, 0 = value valid |
| ins_b_val | input | DATA_W | Source B value |
| bc_valid | input | 1 | Result broadcast valid |
| bc_ready | output | 1 | Broadcast accepted (constant 1) |
| bc_tag | input | TAG_W | Broadcast producer tag |
| bc_val | input | DATA_W | Broadcast result value |
| iss_valid | output | 1 | An instruction is offered to the functional unit |
| iss_ready | input | 1 | Functional unit accepts the offer |
| iss_op | output | OP_W | Offered opcode |
| iss_dst | output | TAG_W | Offered destination tag |
| iss_a | output | DATA_W | Offered source A value |
| iss_b | output | DATA_W | Offered source B value |
| used_count | output | $clog2(NUM_SLOTS+1) | Occupied slot count |

## Verification
The assertions assume the following about the inputs. `ins_valid` is low during reset. Each nonzero tag names at most one in-flight producer, and it is broadcast only after the instruction that waits on it has been inserted or in the same cycle. `iss_ready` may stall for any number of cycles. The stimulus gives every test its own tags and keeps the insert request low throughout reset. It broadcasts each producer tag once and holds back broadcasts so that the age order can be observed with the issue port stalled.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_READY = 2'd2
    } slot_state_e;
endpackage

// File: rtl/rs_free_find.sv
module rs_free_find #(
    parameter int NUM_SLOTS = 4
) (
    input  logic [NUM_SLOTS-1:0] busy,
    output logic [NUM_SLOTS-1:0] sel,
    output logic                 any_free
);
    always_comb begin
        sel      = '0;
        any_free = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (!busy[i] && !any_free) begin
                sel[i]   = 1'b1;
                any_free = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rs_oldest_pick.sv
module rs_oldest_pick #(
    parameter int NUM_SLOTS = 4,
    parameter int AGE_W     = 2
) (
    input  logic [NUM_SLOTS-1:0]            req,
    input  logic [NUM_SLOTS-1:0][AGE_W-1:0] age,
    output logic [NUM_SLOTS-1:0]            grant,
    output logic [AGE_W-1:0]                pick_idx,
    output logic [AGE_W-1:0]                pick_age,
    output logic                            any_req
);
    always_comb begin
        grant    = '0;
        pick_idx = '0;
        pick_age = '0;
        any_req  = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (req[i] && (!any_req || age[i] < pick_age)) begin
                any_req  = 1'b1;
                pick_idx = AGE_W'(i);
                pick_age = age[i];
            end
        end
        if (any_req) begin
            grant[pick_idx] = 1'b1;
        end
    end
endmodule

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4,
    parameter int OP_W   = 4,
    parameter int AGE_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [OP_W-1:0]   ld_op,
    input  logic [TAG_W-1:0]  ld_dst,
    input  logic [TAG_W-1:0]  ld_a_tag,
    input  logic [DATA_W-1:0] ld_a_val,
    input  logic [TAG_W-1:0]  ld_b_tag,
    input  logic [DATA_W-1:0] ld_b_val,
    input  logic [AGE_W-1:0]  ld_age,
    input  logic              bc_hit,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_val,
    input  logic              take,
    input  logic              age_dec,
    output logic              busy,
    output logic              req,
    output logic [AGE_W-1:0]  age,
    output logic [OP_W-1:0]   op,
    output logic [TAG_W-1:0]  dst,
    output logic [DATA_W-1:0] a_val,
    output logic [DATA_W-1:0] b_val
);
    slot_state_e state_q, state_d;

    logic              a_rdy_q, b_rdy_q;
    logic [TAG_W-1:0]  a_tag_q, b_tag_q;
    logic [DATA_W-1:0] a_val_q, b_val_q;
    logic [OP_W-1:0]   op_q;
    logic [TAG_W-1:0]  dst_q;
    logic [AGE_W-1:0]  age_q;

    // capture of a broadcast by the incoming instruction
    logic              a_snoop, b_snoop;
    logic              a_rdy_ld, b_rdy_ld;
    logic [DATA_W-1:0] a_val_ld, b_val_ld;
    // capture by an instruction already waiting
    logic              a_wake, b_wake;

    always_comb begin
        a_snoop  = (ld_a_tag != '0) && bc_hit && (bc_tag == ld_a_tag);
        b_snoop  = (ld_b_tag != '0) && bc_hit && (bc_tag == ld_b_tag);
        a_rdy_ld = (ld_a_tag == '0) || a_snoop;
        b_rdy_ld = (ld_b_tag == '0) || b_snoop;
        a_val_ld = a_snoop ? bc_val : ld_a_val;
        b_val_ld = b_snoop ? bc_val : ld_b_val;
        a_wake   = (state_q == SLOT_WAIT) && !a_rdy_q && bc_hit && (bc_tag == a_tag_q);
        b_wake   = (state_q == SLOT_WAIT) && !b_rdy_q && bc_hit && (bc_tag == b_tag_q);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE: begin
                if (load) begin
                    state_d = (a_rdy_ld && b_rdy_ld) ? SLOT_READY : SLOT_WAIT;
                end
            end
            SLOT_WAIT: begin
                if ((a_rdy_q || a_wake) && (b_rdy_q || b_wake)) begin
                    state_d = SLOT_READY;
                end
            end
            SLOT_READY: begin
                if (take) begin
                    state_d = SLOT_FREE;
                end
            end
            default: state_d = SLOT_FREE;
        endcase
    end

    // outputs
    always_comb begin
        busy  = (state_q != SLOT_FREE);
        req   = (state_q == SLOT_READY);
        age   = age_q;
        op    = op_q;
        dst   = dst_q;
        a_val = a_val_q;
        b_val = b_val_q;
    end

    // payload and operand capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_rdy_q <= 1'b0;
            b_rdy_q <= 1'b0;
            a_tag_q <= '0;
            b_tag_q <= '0;
            a_val_q <= '0;
            b_val_q <= '0;
            op_q    <= '0;
            dst_q   <= '0;
            age_q   <= '0;
        end else if (load && state_q == SLOT_FREE) begin
            a_rdy_q <= a_rdy_ld;
            b_rdy_q <= b_rdy_ld;
            a_tag_q <= ld_a_tag;
            b_tag_q <= ld_b_tag;
            a_val_q <= a_val_ld;
            b_val_q <= b_val_ld;
            op_q    <= ld_op;
            dst_q   <= ld_dst;
            age_q   <= ld_age;
        end else begin
            if (a_wake) begin
                a_rdy_q <= 1'b1;
                a_val_q <= bc_val;
            end
            if (b_wake) begin
                b_rdy_q <= 1'b1;
                b_val_q <= bc_val;
            end
            if (age_dec) begin
                age_q <= age_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/rs_issue_pool.sv
module rs_issue_pool #(
    parameter int NUM_SLOTS = 4,
    parameter int DATA_W    = 32,
    parameter int TAG_W     = 4,
    parameter int OP_W      = 4,
    localparam int AGE_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    output logic              ins_ready,
    input  logic [OP_W-1:0]   ins_op,
    input  logic [TAG_W-1:0]  ins_dst,
    input  logic [TAG_W-1:0]  ins_a_tag,
    input  logic [DATA_W-1:0] ins_a_val,
    input  logic [TAG_W-1:0]  ins_b_tag,
    input  logic [DATA_W-1:0] ins_b_val,
    input  logic              bc_valid,
    output logic              bc_ready,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_val,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic [OP_W-1:0]   iss_op,
    output logic [TAG_W-1:0]  iss_dst,
    output logic [DATA_W-1:0] iss_a,
    output logic [DATA_W-1:0] iss_b,
    output logic [CNT_W-1:0]  used_count
);
    logic [NUM_SLOTS-1:0]             slot_busy;
    logic [NUM_SLOTS-1:0]             slot_req;
    logic [NUM_SLOTS-1:0]             slot_load;
    logic [NUM_SLOTS-1:0]             slot_grant;
    logic [NUM_SLOTS-1:0]             slot_take;
    logic [NUM_SLOTS-1:0]             slot_age_dec;
    logic [NUM_SLOTS-1:0][AGE_W-1:0]  slot_age;
    logic [NUM_SLOTS-1:0][OP_W-1:0]   slot_op;
    logic [NUM_SLOTS-1:0][TAG_W-1:0]  slot_dst;
    logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_a;
    logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_b;

    logic [NUM_SLOTS-1:0] free_sel;
    logic                 any_free;
    logic [AGE_W-1:0]     pick_idx;
    logic [AGE_W-1:0]     pick_age;
    logic                 any_req;
    logic                 ins_fire;
    logic                 iss_fire;
    logic                 bc_hit;
    logic [CNT_W-1:0]     cnt;
    logic [CNT_W-1:0]     new_rank;

    rs_free_find #(.NUM_SLOTS(NUM_SLOTS)) free_i (
        .busy     (slot_busy),
        .sel      (free_sel),
        .any_free (any_free)
    );

    rs_oldest_pick #(.NUM_SLOTS(NUM_SLOTS), .AGE_W(AGE_W)) pick_i (
        .req      (slot_req),
        .age      (slot_age),
        .grant    (slot_grant),
        .pick_idx (pick_idx),
        .pick_age (pick_age),
        .any_req  (any_req)
    );

    always_comb begin
        cnt = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            cnt = cnt + CNT_W'(slot_busy[i]);
        end
        ins_ready  = any_free;
        ins_fire   = ins_valid && any_free;
        iss_valid  = any_req;
        iss_fire   = any_req && iss_ready;
        bc_ready   = 1'b1;
        bc_hit     = bc_valid && (bc_tag != '0);
        used_count = cnt;
        new_rank   = cnt - CNT_W'(iss_fire);
        iss_op     = slot_op[pick_idx];
        iss_dst    = slot_dst[pick_idx];
        iss_a      = slot_a[pick_idx];
        iss_b      = slot_b[pick_idx];
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_comb begin
            slot_load[g]    = ins_fire && free_sel[g];
            slot_take[g]    = iss_fire && slot_grant[g];
            slot_age_dec[g] = iss_fire && slot_busy[g] && (slot_age[g] > pick_age);
        end

        rs_slot #(
            .DATA_W (DATA_W),
            .TAG_W  (TAG_W),
            .OP_W   (OP_W),
            .AGE_W  (AGE_W)
        ) slot_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (slot_load[g]),
            .ld_op    (ins_op),
            .ld_dst   (ins_dst),
            .ld_a_tag (ins_a_tag),
            .ld_a_val (ins_a_val),
            .ld_b_tag (ins_b_tag),
            .ld_b_val (ins_b_val),
            .ld_age   (new_rank[AGE_W-1:0]),
            .bc_hit   (bc_hit),
            .bc_tag   (bc_tag),
            .bc_val   (bc_val),
            .take     (slot_take[g]),
            .age_dec  (slot_age_dec[g]),
            .busy     (slot_busy[g]),
            .req      (slot_req[g]),
            .age      (slot_age[g]),
            .op       (slot_op[g]),
            .dst      (slot_dst[g]),
            .a_val    (slot_a[g]),
            .b_val    (slot_b[g])
        );
    end
endmodule

// File: rtl/rs_issue_pool_chk.sv
module rs_issue_pool_chk #(
    parameter int NUM_SLOTS = 4,
    parameter int CNT_W     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ins_valid,
    input logic                 ins_ready,
    input logic                 iss_valid,
    input logic                 iss_ready,
    input logic [CNT_W-1:0]     used_count,
    input logic [NUM_SLOTS-1:0] slot_grant
);
    p_full_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(used_count) == NUM_SLOTS) |-> !ins_ready);

    p_count_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (int'(used_count) == int'($past(used_count))
            + int'($past(ins_valid && ins_ready)) - int'($past(iss_valid && iss_ready))));

    p_single_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_grant));

    p_offer_has_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> ($countones(slot_grant) == 1));

    p_offer_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready) |=> iss_valid);

    p_empty_no_offer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (used_count == '0) |-> !iss_valid);
endmodule

bind rs_issue_pool rs_issue_pool_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .CNT_W     (CNT_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ins_valid  (ins_valid),
    .ins_ready  (ins_ready),
    .iss_valid  (iss_valid),
    .iss_ready  (iss_ready),
    .used_count (used_count),
    .slot_grant (slot_grant)
);

// File: tb/rs_issue_pool_tb_top.sv
module rs_issue_pool_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0;
    logic        ins_ready;
    logic [3:0]  ins_op = '0;
    logic [3:0]  ins_dst = '0;
    logic [3:0]  ins_a_tag = '0;
    logic [31:0] ins_a_val = '0;
    logic [3:0]  ins_b_tag = '0;
    logic [31:0] ins_b_val = '0;
    logic        bc_valid = 1'b0;
    logic        bc_ready;
    logic [3:0]  bc_tag = '0;
    logic [31:0] bc_val = '0;
    logic        iss_valid;
    logic        iss_ready = 1'b0;
    logic [3:0]  iss_op;
    logic [3:0]  iss_dst;
    logic [31:0] iss_a;
    logic [31:0] iss_b;
    logic [2:0]  used_count;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rs_issue_pool dut_i (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_op(ins_op), .ins_dst(ins_dst),
        .ins_a_tag(ins_a_tag), .ins_a_val(ins_a_val), .ins_b_tag(ins_b_tag), .ins_b_val(ins_b_val),
        .bc_valid(bc_valid), .bc_ready(bc_ready), .bc_tag(bc_tag), .bc_val(bc_val),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op), .iss_dst(iss_dst),
        .iss_a(iss_a), .iss_b(iss_b), .used_count(used_count)
    );

    typedef struct packed {
        logic [3:0]  a_tag;
        logic [31:0] a_val;
        logic [3:0]  b_tag;
        logic [31:0] b_val;
        logic        bc1_v;
        logic [3:0]  bc1_tag;
        logic [31:0] bc1_val;
        logic        bc2_v;
        logic [3:0]  bc2_tag;
        logic [31:0] bc2_val;
        logic [31:0] exp_a;
        logic [31:0] exp_b;
    } vec_t;

    // a_tag a_val b_tag b_val | bc with insert | bc one cycle later | expected a, b
    localparam vec_t VECS [6] = '{
        '{4'd0, 32'd11,  4'd0, 32'd22,  1'b0, 4'd0, 32'd0,      1'b0, 4'd0, 32'd0,    32'd11,   32'd22},
        '{4'd3, 32'd0,   4'd0, 32'd5,   1'b0, 4'd0, 32'd0,      1'b1, 4'd3, 32'h33,   32'h33,   32'd5},
        '{4'd0, 32'd7,   4'd5, 32'd1,   1'b1, 4'd5, 32'h55,     1'b0, 4'd0, 32'd0,    32'd7,    32'h55},
        '{4'd2, 32'd0,   4'd2, 32'd0,   1'b0, 4'd0, 32'd0,      1'b1, 4'd2, 32'h77,   32'h77,   32'h77},
        '{4'd6, 32'd9,   4'd0, 32'd8,   1'b1, 4'd7, 32'hbad,    1'b1, 4'd6, 32'h66,   32'h66,   32'd8},
        '{4'd0, 32'd1,   4'd4, 32'd0,   1'b1, 4'd0, 32'hdead,   1'b1, 4'd4, 32'h44,   32'd1,    32'h44}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [3:0] op, input logic [3:0] dst,
                       input logic [3:0] at, input logic [31:0] av,
                       input logic [3:0] bt, input logic [31:0] bv);
        ins_valid = 1'b1; ins_op = op; ins_dst = dst;
        ins_a_tag = at; ins_a_val = av; ins_b_tag = bt; ins_b_val = bv;
    endtask

    task automatic bcast(input logic v, input logic [3:0] t, input logic [31:0] d);
        bc_valid = v; bc_tag = t; bc_val = d;
    endtask

    task automatic take_one(input logic [3:0] exp_dst, input string req);
        chk(iss_valid == 1'b1, req, 32'(iss_valid), 32'd1);
        chk(iss_dst == exp_dst, req, 32'(iss_dst), 32'(exp_dst));
        iss_ready = 1'b1;
        @(negedge clk);
        iss_ready = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, R11 broadcast always accepted
        chk(ins_ready == 1'b1, "R1", 32'(ins_ready), 32'd1);
        chk(iss_valid == 1'b0, "R1", 32'(iss_valid), 32'd0);
        chk(used_count == 3'd0, "R1", 32'(used_count), 32'd0);
        chk(bc_ready == 1'b1, "R11", 32'(bc_ready), 32'd1);

        // table walk: R3 encoding, R4 wakeup, R5 same-cycle capture, R9 tag 0, R10 payload
        for (int i = 0; i < 6; i++) begin
            put(4'(i), 4'(i + 1), VECS[i].a_tag, VECS[i].a_val, VECS[i].b_tag, VECS[i].b_val);
            bcast(VECS[i].bc1_v, VECS[i].bc1_tag, VECS[i].bc1_val);
            @(negedge clk);
            ins_valid = 1'b0;
            bcast(VECS[i].bc2_v, VECS[i].bc2_tag, VECS[i].bc2_val);
            @(negedge clk);
            bcast(1'b0, 4'd0, 32'd0);
            chk(iss_valid == 1'b1, "R4", 32'(iss_valid), 32'd1);
            chk(iss_a == VECS[i].exp_a, "R3 R5 operand a", iss_a, VECS[i].exp_a);
            chk(iss_b == VECS[i].exp_b, "R3 R5 operand b", iss_b, VECS[i].exp_b);
            chk(iss_op == 4'(i), "R10", 32'(iss_op), 32'(i));
            chk(used_count == 3'd1, "R2", 32'(used_count), 32'd1);
            take_one(4'(i + 1), "R10");
            chk(used_count == 3'd0, "R8", 32'(used_count), 32'd0);
            chk(iss_valid == 1'b0, "R6", 32'(iss_valid), 32'd0);
        end

        // R6 no offer while pending; R9 ignored broadcasts; R4 wake
        put(4'd2, 4'd14, 4'd9, 32'd0, 4'd0, 32'd3);
        @(negedge clk);
        ins_valid = 1'b0;
        chk(iss_valid == 1'b0, "R6", 32'(iss_valid), 32'd0);
        bcast(1'b0, 4'd9, 32'h99);
        @(negedge clk);
        chk(iss_valid == 1'b0, "R9 bc_valid low", 32'(iss_valid), 32'd0);
        bcast(1'b1, 4'd0, 32'h5);
        @(negedge clk);
        chk(iss_valid == 1'b0, "R9 tag zero", 32'(iss_valid), 32'd0);
        bcast(1'b1, 4'd9, 32'h99);
        @(negedge clk);
        bcast(1'b0, 4'd0, 32'd0);
        chk(iss_a == 32'h99, "R4", iss_a, 32'h99);
        take_one(4'd14, "R4");

        // fill: entries dst 8..11 waiting on tags 1..4
        for (int k = 0; k < 4; k++) begin
            put(4'(k), 4'(8 + k), 4'(k + 1), 32'd0, 4'd0, 32'(k));
            @(negedge clk);
        end
        ins_valid = 1'b0;
        chk(used_count == 3'd4, "R2", 32'(used_count), 32'd4);
        chk(ins_ready == 1'b0, "R2", 32'(ins_ready), 32'd0);
        put(4'd15, 4'd15, 4'd0, 32'd0, 4'd0, 32'd0);
        @(negedge clk);
        ins_valid = 1'b0;
        chk(used_count == 3'd4, "R2 insert while full", 32'(used_count), 32'd4);
        bcast(1'b1, 4'd3, 32'h3);
        @(negedge clk);
        bcast(1'b1, 4'd2, 32'h2);
        @(negedge clk);
        bcast(1'b1, 4'd4, 32'h4);
        @(negedge clk);
        bcast(1'b0, 4'd0, 32'd0);
        chk(iss_dst == 4'd9, "R7", 32'(iss_dst), 32'd9);
        chk(iss_op == 4'd1, "R10", 32'(iss_op), 32'd1);
        @(negedge clk);
        chk(iss_valid == 1'b1 && iss_dst == 4'd9, "R8 hold", 32'(iss_dst), 32'd9);
        chk(used_count == 3'd4, "R8 hold", 32'(used_count), 32'd4);
        iss_ready = 1'b1;
        chk(ins_ready == 1'b0, "R8 not free yet", 32'(ins_ready), 32'd0);
        @(negedge clk);
        iss_ready = 1'b0;
        chk(used_count == 3'd3, "R8", 32'(used_count), 32'd3);
        chk(ins_ready == 1'b1, "R8 freed", 32'(ins_ready), 32'd1);
        chk(iss_dst == 4'd10, "R7", 32'(iss_dst), 32'd10);
        bcast(1'b1, 4'd1, 32'h1);
        @(negedge clk);
        bcast(1'b0, 4'd0, 32'd0);
        chk(iss_dst == 4'd8, "R7 older wakes late", 32'(iss_dst), 32'd8);
        // issue and insert in the same cycle
        put(4'd5, 4'd12, 4'd0, 32'd1, 4'd0, 32'd2);
        iss_ready = 1'b1;
        @(negedge clk);
        ins_valid = 1'b0;
        iss_ready = 1'b0;
        chk(used_count == 3'd3, "R2", 32'(used_count), 32'd3);
        take_one(4'd10, "R7");
        take_one(4'd11, "R7");
        take_one(4'd12, "R7");
        chk(used_count == 3'd0, "R8", 32'(used_count), 32'd0);
        chk(iss_valid == 1'b0, "R6", 32'(iss_valid), 32'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule